// File: doc/BRIEF.md
# Local Bus Hold Arbiter

This block decides who owns the local bus: the processor's own bus interface or an external master that asks for the bus. The external master raises a level-sensitive request. The arbiter lets the current processor bus cycle finish and waits for any locked sequence to end. It then turns off the processor's bus drivers and raises an acknowledge. While the bus is handed over, every chip-select output is held at its inactive high level.

Internal refresh requests compete for the same bus. A refresh that arrives together with an external request wins, and the hand-over waits until the refresh is done. A refresh that arrives while the external master owns the bus makes the arbiter withdraw the acknowledge while the request is still high. The arbiter then waits for the master to let go, serves the refresh, and only after that looks at the external request again.

The bus drivers always stay floated for one cycle on each side of the acknowledge pulse. Because of this, the two masters never drive the bus in the same cycle.

Top module: `hold_bus_arbiter`

## Requirements
- R1: After reset, `hold_ack`, `rfsh_gnt` and every bit of `drv_float` are 0, and `cs_n_out` equals `cs_n_in`.
- R2: With the bus idle (`cyc_busy`=0, `lock_act`=0, `rfsh_req`=0), a `hold_req` first seen at a rising edge makes `drv_float` go all ones after the second edge and `hold_ack` go 1 after the third edge. `drv_float` therefore rises exactly one cycle before `hold_ack`.
- R3: While `cyc_busy` is 1, the bus is not handed over: `hold_ack` and `drv_float` stay 0. `drv_float` rises at the edge after the one where `cyc_busy` is seen at 0.
- R4: While `lock_act` is 1, the hand-over is withheld in the same way as for R3, even if `cyc_busy` is 0.
- R5: Whenever `drv_float` is all ones, every bit of `cs_n_out` is 1, whatever `cs_n_in` holds. At all other times `cs_n_out` follows `cs_n_in`.
- R6: When `hold_req` falls during a grant, `hold_ack` goes 0 at the next edge and `drv_float` goes 0 one edge later.
- R7: When `rfsh_req` and `hold_req` rise in the same cycle, `rfsh_gnt` goes 1 at the next edge and `hold_ack` stays 0. `hold_ack` reaches 1 on the fourth edge after `rfsh_req` is seen low.
- R8: When `rfsh_req` is 1 during a grant, `hold_ack` goes 0 at the next edge even though `hold_req` is still 1. `drv_float` stays all ones and `rfsh_gnt` stays 0 for as long as `hold_req` stays 1.
- R9: After such a reclaim, the edge that sees `hold_req` at 0 sets `rfsh_gnt` to 1 and `drv_float` to 0. A `hold_req` still present when `rfsh_req` drops is then handled as a new request, with `hold_ack` reaching 1 on the fourth edge.
- R10: With no grant in force, `rfsh_req` gives `rfsh_gnt`=1 at the next edge. `rfsh_gnt` stays 1 while `rfsh_req` stays 1 and drops at the edge after `rfsh_req` is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hold_req | input | 1 | External master asks for the bus (level) |
| cyc_busy | input | 1 | A processor bus cycle is in progress |
| lock_act | input | 1 | A locked transfer sequence is in progress |
| rfsh_req | input | 1 | Internal refresh needs the bus |
| cs_n_in | input | NCS | Chip selects from the decoder, active low |
| hold_ack | output | 1 | Bus handed to the external master |
| rfsh_gnt | output | 1 | Bus granted to the refresh cycle |
| drv_float | output | NGRP | One float enable per driver group (1 = high impedance) |
| cs_n_out | output | NCS | Chip selects to the pins, forced high while floated |

## Verification
The bench uses the default parameters: six chip selects and four driver groups. With these values, a single non-trivial `cs_n_in` pattern shows both that every select is forced high during a grant and that the selects pass through unchanged outside it. Every `drv_float` bit is compared as a full vector, so a group that lags behind the others shows up. The directed scenarios count edges through each hand-over path: idle grant, busy and locked stalls, release, simultaneous refresh, and reclaim followed by a renewed request.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT_END = 3'd1,
    ST_HANDOFF  = 3'd2,
    ST_GRANTED  = 3'd3,
    ST_RETURN   = 3'd4,
    ST_RECLAIM  = 3'd5,
    ST_REFRESH  = 3'd6
  } arb_st_t;
endpackage

// File: rtl/hold_rst_sync.sv
module hold_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/hold_arb_fsm.sv
module hold_arb_fsm
  import hold_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  input  logic cyc_busy,
  input  logic lock_act,
  input  logic rfsh_req,
  output logic hold_ack,
  output logic float_en,
  output logic rfsh_gnt
);
  arb_st_t st_q, st_nxt;
  logic    st_upd;

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_IDLE:     if (rfsh_req) st_nxt = ST_REFRESH;
                   else if (hold_req) st_nxt = ST_WAIT_END;
      ST_WAIT_END: if (rfsh_req) st_nxt = ST_REFRESH;
                   else if (!hold_req) st_nxt = ST_IDLE;
                   else if (!cyc_busy && !lock_act) st_nxt = ST_HANDOFF;
      ST_HANDOFF:  st_nxt = ST_GRANTED;
      ST_GRANTED:  if (!hold_req) st_nxt = ST_RETURN;
                   else if (rfsh_req) st_nxt = ST_RECLAIM;
      ST_RETURN:   st_nxt = ST_IDLE;
      ST_RECLAIM:  if (!hold_req) st_nxt = ST_REFRESH;
      ST_REFRESH:  if (!rfsh_req) st_nxt = ST_IDLE;
      default:     st_nxt = ST_IDLE;
    endcase
  end

  assign st_upd = (st_nxt != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= ST_IDLE;
    else if (st_upd) st_q <= st_nxt;
  end

  assign hold_ack = (st_q == ST_GRANTED);
  assign float_en = (st_q == ST_HANDOFF) || (st_q == ST_GRANTED) ||
                    (st_q == ST_RETURN)  || (st_q == ST_RECLAIM);
  assign rfsh_gnt = (st_q == ST_REFRESH);

  AST_FLOAT_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> $past(float_en)); // R2
  AST_GRANT_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> $past(!cyc_busy && !lock_act, 2)); // R3
  AST_FLOAT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack) |-> float_en); // R6
  AST_RECLAIM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack && hold_req && rfsh_req |=> !hold_ack && float_en); // R8
  AST_RFSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfsh_gnt) |-> $past(rfsh_req) && !float_en); // R10
endmodule

// File: rtl/hold_bus_isolate.sv
module hold_bus_isolate #(
  parameter int NCS  = 6,
  parameter int NGRP = 4
) (
  input  logic            float_en,
  input  logic [NCS-1:0]  cs_n_in,
  output logic [NCS-1:0]  cs_n_out,
  output logic [NGRP-1:0] drv_float
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign drv_float[g] = float_en;
  end

  for (genvar c = 0; c < NCS; c++) begin : g_cs
    assign cs_n_out[c] = cs_n_in[c] | float_en;
  end
endmodule

// File: rtl/hold_bus_arbiter.sv
module hold_bus_arbiter #(
  parameter int NCS  = 6,
  parameter int NGRP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_req,
  input  logic            cyc_busy,
  input  logic            lock_act,
  input  logic            rfsh_req,
  input  logic [NCS-1:0]  cs_n_in,
  output logic            hold_ack,
  output logic            rfsh_gnt,
  output logic [NGRP-1:0] drv_float,
  output logic [NCS-1:0]  cs_n_out
);
  logic rst_s_n;
  logic float_en;

  hold_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  hold_arb_fsm fsm_i (
    .clk(clk), .rst_n(rst_s_n), .hold_req(hold_req), .cyc_busy(cyc_busy),
    .lock_act(lock_act), .rfsh_req(rfsh_req), .hold_ack(hold_ack),
    .float_en(float_en), .rfsh_gnt(rfsh_gnt)
  );

  hold_bus_isolate #(.NCS(NCS), .NGRP(NGRP)) iso_i (
    .float_en(float_en), .cs_n_in(cs_n_in), .cs_n_out(cs_n_out),
    .drv_float(drv_float)
  );

  AST_CS_HIGH_IN_GRANT: assert property (@(posedge clk) disable iff (!rst_s_n)
    hold_ack |-> (&cs_n_out)); // R5
  AST_NO_DUAL_OWNER: assert property (@(posedge clk) disable iff (!rst_s_n)
    rfsh_gnt |-> !hold_ack && (drv_float == '0)); // R9
endmodule

// File: tb/hold_bus_arbiter_tb_top.sv
module hold_bus_arbiter_tb_top;
  localparam int NCS  = 6;
  localparam int NGRP = 4;
  localparam logic [NGRP-1:0] FL_ON = '1;
  localparam logic [NGRP-1:0] FL_OFF = '0;

  logic clk = 1'b0;
  logic rst_n, hold_req, cyc_busy, lock_act, rfsh_req;
  logic [NCS-1:0]  cs_n_in;
  logic            hold_ack, rfsh_gnt;
  logic [NGRP-1:0] drv_float;
  logic [NCS-1:0]  cs_n_out;
  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  hold_bus_arbiter #(.NCS(NCS), .NGRP(NGRP)) dut_i (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .cyc_busy(cyc_busy),
    .lock_act(lock_act), .rfsh_req(rfsh_req), .cs_n_in(cs_n_in),
    .hold_ack(hold_ack), .rfsh_gnt(rfsh_gnt), .drv_float(drv_float),
    .cs_n_out(cs_n_out)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input string req, input logic ea, input logic eg,
                     input logic [NGRP-1:0] ef);
    logic [NCS-1:0] ecs;
    ecs = (ef == FL_ON) ? '1 : cs_n_in;
    total++;
    if (hold_ack !== ea || rfsh_gnt !== eg || drv_float !== ef || cs_n_out !== ecs) begin
      bad++;
      $display("FAIL %s: ack=%b gnt=%b flt=%b cs=%b expected ack=%b gnt=%b flt=%b cs=%b",
               req, hold_ack, rfsh_gnt, drv_float, cs_n_out, ea, eg, ef, ecs);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; hold_req = 0; cyc_busy = 0; lock_act = 0; rfsh_req = 0;
    cs_n_in = 6'b101100;
    step(2);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset", 0, 0, FL_OFF);
  endtask

  task automatic t_idle_grant();
    do_reset();
    hold_req = 1;
    step(1); chk("R2 edge1", 0, 0, FL_OFF);
    step(1); chk("R2 float first", 0, 0, FL_ON);
    step(1); chk("R2 ack", 1, 0, FL_ON);
    cs_n_in = 6'b010011;
    #1 chk("R5 cs forced", 1, 0, FL_ON);
    hold_req = 0;
    step(1); chk("R6 ack drop", 0, 0, FL_ON);
    step(1); chk("R6 float drop", 0, 0, FL_OFF);
    chk("R5 cs pass", 0, 0, FL_OFF);
  endtask

  task automatic t_busy();
    do_reset();
    cyc_busy = 1; hold_req = 1;
    step(4); chk("R3 busy holds", 0, 0, FL_OFF);
    cyc_busy = 0;
    step(1); chk("R3 float after busy", 0, 0, FL_ON);
    step(1); chk("R3 ack", 1, 0, FL_ON);
  endtask

  task automatic t_lock();
    do_reset();
    lock_act = 1; hold_req = 1;
    step(5); chk("R4 lock withholds", 0, 0, FL_OFF);
    lock_act = 0;
    step(1); chk("R4 float after lock", 0, 0, FL_ON);
    step(1); chk("R4 ack", 1, 0, FL_ON);
  endtask

  task automatic t_simul();
    do_reset();
    hold_req = 1; rfsh_req = 1;
    step(1); chk("R7 refresh first", 0, 1, FL_OFF);
    step(2); chk("R7 still refresh", 0, 1, FL_OFF);
    rfsh_req = 0;
    step(3); chk("R7 pre-ack", 0, 0, FL_ON);
    step(1); chk("R7 ack after refresh", 1, 0, FL_ON);
  endtask

  task automatic t_reclaim();
    do_reset();
    hold_req = 1;
    step(3); chk("R8 granted", 1, 0, FL_ON);
    rfsh_req = 1;
    step(1); chk("R8 ack withdrawn", 0, 0, FL_ON);
    step(2); chk("R8 waits master", 0, 0, FL_ON);
    hold_req = 0;
    step(1); chk("R9 refresh served", 0, 1, FL_OFF);
    hold_req = 1;
    step(1); chk("R10 gnt held", 0, 1, FL_OFF);
    rfsh_req = 0;
    step(1); chk("R10 gnt drop", 0, 0, FL_OFF);
    step(2); chk("R9 rehandoff", 0, 0, FL_ON);
    step(1); chk("R9 new ack", 1, 0, FL_ON);
  endtask

  initial begin
    t_reset();
    t_idle_grant();
    t_busy();
    t_lock();
    t_simul();
    t_reclaim();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule